// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block holds one 32-bit word per hart on a simple register bus. Software writes a hart's word to send it an inter-processor interrupt. Each hart has one level interrupt output, driven from a pending flop inside the bank. The bus carries whole aligned words only. Any other access reads as zero and changes nothing.

A build-time mode parameter sets how the bank behaves. In machine mode the word works as a normal read/write flag. Bit 0 of a write sets or clears the line, and a read returns the line's state. In supervisor mode the bank can only raise a line. A write of zero leaves the line alone, and every read returns zero. Each hart then clears its own line through a local clear input.

Top module: `swi_bank`

## Requirements
- R1: While `rst_n` is low, every `swi_irq` bit is 0 and `bus_rvalid` is 0.
- R2: An accepted write whose data bit 0 is 1 sets `swi_irq[i]` on the clock edge that samples the write. The hart index i is `bus_addr[ADDR_W-1:2]`. The other lines do not change, except through R9.
- R3: In machine mode, an accepted write whose data bit 0 is 0 clears `swi_irq[i]` on that edge.
- R4: In supervisor mode, an accepted write whose data bit 0 is 0 leaves `swi_irq[i]` unchanged.
- R5: Every read request (`bus_sel`=1, `bus_we`=0) gets `bus_rvalid`=1 one cycle later. In machine mode, an accepted read returns `swi_irq[i]` in bit 0, taken at the request edge, with bits 31:1 zero.
- R6: In supervisor mode, every read response is all zeros.
- R7: An access is accepted only when all three of these hold: `bus_be` is 4'b1111, `bus_addr[1:0]` is 00, and the index is below NUM_HARTS. A write that is not accepted changes no line. A read that is not accepted returns zero.
- R8: Data bits 31:1 of a write have no effect. Only bit 0 decides between setting and clearing.
- R9: In supervisor mode, `local_clr[i]` high at a clock edge clears `swi_irq[i]`. If an accepted set write to the same hart arrives in that cycle, the set wins.
- R10: In machine mode, `local_clr` has no effect on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset in the bank |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_be | input | 4 | Byte enables; must be all ones to be accepted |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read request |
| bus_rdata | output | 32 | Read response data |
| local_clr | input | NUM_HARTS | Per-hart local clear (supervisor mode only) |
| swi_irq | output | NUM_HARTS | Per-hart software interrupt lines |

## Verification
A wrong pending flop shows on its `swi_irq` pin at the first falling edge after the access that should have changed it. It also shows one cycle later in machine-mode read data. A decode error, such as a misaligned or out-of-range access reaching a hart, shows as a line changing where the model holds it. Mode errors show as a zero write or a local clear acting in the wrong mode. The bench drives the same stimulus into a machine-mode bank and a supervisor-mode bank, so a mode-dependent fault shows as a mismatch on one instance and not the other.

// File: rtl/swi_bank_pkg.sv
package swi_bank_pkg;

    typedef enum logic {
        SWI_MODE_MACHINE = 1'b0,
        SWI_MODE_SUPER   = 1'b1
    } swi_mode_e;

    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_BW = BUS_DW / 8;
    localparam logic [BUS_BW-1:0] FULL_WORD = '1;

    typedef struct packed {
        logic pend;
    } cell_state_t;

    typedef struct packed {
        logic              valid;
        logic [BUS_DW-1:0] data;
    } rsp_state_t;

endpackage

// File: rtl/swi_addr_decode.sv
module swi_addr_decode
    import swi_bank_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned IDX_W     = 2
) (
    input  logic                 sel,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BUS_BW-1:0]    be,
    output logic [NUM_HARTS-1:0] hart_wr,
    output logic                 rd_req,
    output logic                 rd_hit,
    output logic [IDX_W-1:0]     rd_idx
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              shape_ok;
    logic              in_range;
    logic              accept;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        shape_ok = (be == FULL_WORD) && (addr[1:0] == 2'b00);
        in_range = 32'(word) < NUM_HARTS;
        accept   = sel && shape_ok && in_range;
        rd_req   = sel && !we;
        rd_hit   = accept && !we;
        rd_idx   = IDX_W'(word);
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hit
        assign hart_wr[h] = accept && we && (32'(word) == 32'(h));
    end

endmodule

// File: rtl/swi_hart_cell.sv
module swi_hart_cell
    import swi_bank_pkg::*;
#(
    parameter swi_mode_e MODE = SWI_MODE_MACHINE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic local_clr,
    output logic irq
);

    cell_state_t st_d, st_q;
    logic        clr_src;

    always_comb begin
        // machine mode clears on a bus write; supervisor mode on the local input
        clr_src   = (MODE == SWI_MODE_MACHINE) ? wr_hit : local_clr;
        st_d      = st_q;
        st_d.pend = (wr_hit && wr_bit) || (st_q.pend && !clr_src);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend;

endmodule

// File: rtl/swi_read_port.sv
module swi_read_port
    import swi_bank_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned IDX_W     = 2,
    parameter swi_mode_e   MODE      = SWI_MODE_MACHINE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 rd_hit,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [NUM_HARTS-1:0] pend,
    output logic                 rvalid,
    output logic [BUS_DW-1:0]    rdata
);

    rsp_state_t rsp_d, rsp_q;
    logic       sel_bit;

    always_comb begin
        sel_bit       = rd_hit && pend[rd_idx];
        rsp_d         = '0;
        rsp_d.valid   = rd_req;
        rsp_d.data[0] = (MODE == SWI_MODE_MACHINE) ? sel_bit : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rvalid = rsp_q.valid;
    assign rdata  = rsp_q.data;

endmodule

// File: rtl/swi_bank.sv
module swi_bank
    import swi_bank_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter swi_mode_e   MODE      = SWI_MODE_MACHINE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [3:0]           bus_be,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_HARTS-1:0] local_clr,
    output logic [NUM_HARTS-1:0] swi_irq
);

    localparam int unsigned IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    logic [NUM_HARTS-1:0] hart_wr;
    logic                 rd_req;
    logic                 rd_hit;
    logic [IDX_W-1:0]     rd_idx;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:1];

    swi_addr_decode #(
        .NUM_HARTS(NUM_HARTS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) dec_i (
        .sel    (bus_sel),
        .we     (bus_we),
        .addr   (bus_addr),
        .be     (bus_be),
        .hart_wr(hart_wr),
        .rd_req (rd_req),
        .rd_hit (rd_hit),
        .rd_idx (rd_idx)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_cell
        swi_hart_cell #(
            .MODE(MODE)
        ) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hart_wr[h]),
            .wr_bit   (bus_wdata[0]),
            .local_clr(local_clr[h]),
            .irq      (swi_irq[h])
        );
    end

    swi_read_port #(
        .NUM_HARTS(NUM_HARTS),
        .IDX_W    (IDX_W),
        .MODE     (MODE)
    ) rdp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_req(rd_req),
        .rd_hit(rd_hit),
        .rd_idx(rd_idx),
        .pend  (swi_irq),
        .rvalid(bus_rvalid),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk
    import swi_bank_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter swi_mode_e   MODE      = SWI_MODE_MACHINE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [3:0]           bus_be,
    input logic                 bus_rvalid,
    input logic [31:0]          bus_rdata,
    input logic [NUM_HARTS-1:0] local_clr,
    input logic [NUM_HARTS-1:0] swi_irq
);

    logic                 good;
    logic                 bad_wr;
    logic                 bad_rd;
    logic [NUM_HARTS-1:0] tgt;
    logic                 unused_chk_hi;

    assign unused_chk_hi = ^bus_wdata[31:1];

    always_comb begin
        good   = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00)
                 && ((32'(bus_addr) >> 2) < NUM_HARTS);
        bad_wr = bus_sel && bus_we && !good;
        bad_rd = bus_sel && !bus_we && !good;
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_tgt
        assign tgt[h] = good && ((32'(bus_addr) >> 2) == 32'(h));
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (swi_irq == '0 && !bus_rvalid));

    // R5
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);

    // R7
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_rd |=> (bus_rdata == '0));

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        // R2
        set_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt[h] && bus_we && bus_wdata[0]) |=> swi_irq[h]);

        if (MODE == SWI_MODE_MACHINE) begin : g_m
            // R3
            clear_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tgt[h] && bus_we && !bus_wdata[0]) |=> !swi_irq[h]);
            // R5
            read_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tgt[h] && !bus_we) |=> (bus_rdata == {31'b0, $past(swi_irq[h])}));
            // R10
            no_local_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(tgt[h] && bus_we) |=> $stable(swi_irq[h]));
        end else begin : g_s
            // R4
            zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tgt[h] && bus_we && !bus_wdata[0] && !local_clr[h]) |=> $stable(swi_irq[h]));
            // R9
            local_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (local_clr[h] && !(tgt[h] && bus_we && bus_wdata[0])) |=> !swi_irq[h]);
            // R9
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (local_clr[h] && tgt[h] && bus_we && bus_wdata[0]) |=> swi_irq[h]);
        end
    end

    if (MODE == SWI_MODE_SUPER) begin : g_sup_rd
        // R6
        sup_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rvalid |-> (bus_rdata == '0));
        // R7
        bad_write_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bad_wr && local_clr == '0) |=> $stable(swi_irq));
    end else begin : g_mach_rd
        // R5
        upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rvalid |-> (bus_rdata[31:1] == '0));
        // R7
        bad_write_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bad_wr |=> $stable(swi_irq));
    end

endmodule

bind swi_bank swi_bank_chk #(
    .NUM_HARTS(NUM_HARTS),
    .ADDR_W   (ADDR_W),
    .MODE     (MODE)
) chk_i (.*);

// File: tb/swi_bank_tb_top.sv
module swi_bank_tb_top;
    import swi_bank_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NH = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    be = '0;
    logic [NH-1:0] clr = '0;

    logic          rv_m, rv_s;
    logic [31:0]   rd_m, rd_s;
    logic [NH-1:0] irq_m, irq_s;

    int total = 0;
    int fails = 0;
    bit done = 0;

    // reference state: index 0 = machine bank, 1 = supervisor bank
    logic [NH-1:0] m_irq [2];
    logic          m_rv  [2];
    logic [31:0]   m_rd  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(SWI_MODE_MACHINE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_be(be), .bus_rvalid(rv_m), .bus_rdata(rd_m),
        .local_clr(clr), .swi_irq(irq_m));

    swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(SWI_MODE_SUPER)) dut_sv_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_be(be), .bus_rvalid(rv_s), .bus_rdata(rd_s),
        .local_clr(clr), .swi_irq(irq_s));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural model, updated on the same edge as the banks
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int md = 0; md < 2; md++) begin
                m_irq[md] <= '0;
                m_rv[md]  <= 1'b0;
                m_rd[md]  <= '0;
            end
        end else begin
            for (int md = 0; md < 2; md++) begin
                automatic bit ok = sel && be == 4'hF && addr[1:0] == 2'b00 && (int'(addr) / 4) < NH;
                automatic int idx = int'(addr) / 4;
                automatic logic [NH-1:0] nxt = m_irq[md];
                if (md == 1) nxt = nxt & ~clr;
                if (ok && we) begin
                    if (wdata[0]) nxt[idx] = 1'b1;
                    else if (md == 0) nxt[idx] = 1'b0;
                end
                m_irq[md] <= nxt;
                m_rv[md]  <= sel && !we;
                m_rd[md]  <= (ok && !we && md == 0) ? {31'b0, m_irq[0][idx]} : 32'b0;
            end
        end
    end

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R3 R10 machine lines vs model", 32'(irq_m), 32'(m_irq[0]));
            chk("R4 R9 supervisor lines vs model", 32'(irq_s), 32'(m_irq[1]));
            chk("R5 machine rvalid vs model", 32'(rv_m), 32'(m_rv[0]));
            chk("R5 machine rdata vs model", rd_m, m_rd[0]);
            chk("R6 supervisor rdata vs model", rd_s, m_rd[1]);
        end
    end

    task automatic op(input bit w, input int a, input logic [31:0] d,
                      input logic [3:0] b, input logic [NH-1:0] c);
        @(negedge clk);
        sel = 1'b1; we = w; addr = AW'(a); wdata = d; be = b; clr = c;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; clr = '0;
    endtask

    task automatic pulse_clr(input logic [NH-1:0] c);
        @(negedge clk);
        clr = c;
        @(negedge clk);
        clr = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 machine lines in reset", 32'(irq_m), 0);
        chk("R1 supervisor lines in reset", 32'(irq_s), 0);
        chk("R1 rvalid in reset", 32'({rv_m, rv_s}), 0);
        rst_n = 1'b1;

        // R2: set hart 1
        op(1, 4, 32'h1, 4'hF, '0);
        chk("R2 machine set hart1", 32'(irq_m), 32'h2);
        chk("R2 supervisor set hart1", 32'(irq_s), 32'h2);

        // R5 / R6: reads
        op(0, 4, 0, 4'hF, '0);
        chk("R5 machine read hart1", rd_m, 32'h1);
        chk("R5 rvalid after read", 32'(rv_m), 1);
        chk("R6 supervisor read hart1", rd_s, 0);
        op(0, 0, 0, 4'hF, '0);
        chk("R5 machine read hart0", rd_m, 0);

        // R3 / R4: write zero
        op(1, 4, 32'h0, 4'hF, '0);
        chk("R3 machine clear hart1", 32'(irq_m), 0);
        chk("R4 supervisor hold hart1", 32'(irq_s), 32'h2);

        // R8: upper data bits ignored
        op(1, 8, 32'hFFFF_FFFF, 4'hF, '0);
        op(1, 8, 32'hFFFF_FFFE, 4'hF, '0);
        chk("R8 machine clear with upper bits", 32'(irq_m[2]), 0);
        chk("R8 supervisor hold with upper bits", 32'(irq_s[2]), 1);
        op(1, 12, 32'hFFFF_FFFE, 4'hF, '0);
        chk("R8 no set from upper bits", 32'({irq_m[3], irq_s[3]}), 0);

        // R7: rejected accesses
        op(1, 0, 32'h1, 4'hF, '0);
        op(1, 16, 32'h1, 4'hF, '0);
        op(1, 13, 32'h1, 4'hF, '0);
        op(1, 12, 32'h1, 4'h1, '0);
        op(1, 12'hFF0, 32'h1, 4'hF, '0);
        chk("R7 machine lines after bad writes", 32'(irq_m), 32'h1);
        chk("R7 supervisor lines after bad writes", 32'(irq_s), 32'h7);
        op(0, 2, 0, 4'hF, '0);
        chk("R7 misaligned read zero", rd_m, 0);
        op(0, 0, 0, 4'h3, '0);
        chk("R7 partial read zero", rd_m, 0);
        op(0, 16, 0, 4'hF, '0);
        chk("R7 out-of-range read zero", rd_m, 0);

        // R9 / R10: local clear
        pulse_clr(4'b0011);
        chk("R9 supervisor local clear", 32'(irq_s), 32'h4);
        chk("R10 machine ignores local clear", 32'(irq_m), 32'h1);
        op(1, 12, 32'h1, 4'hF, 4'b1000);
        chk("R9 set wins over clear", 32'(irq_s[3]), 1);
        chk("R10 machine set hart3", 32'(irq_m), 32'h9);

        // mixed traffic, checked by the model every cycle
        for (int n = 0; n < 400; n++) begin
            automatic int a = ($urandom % 4 == 0) ? int'($urandom % 24) : 4 * int'($urandom % NH);
            automatic logic [3:0] b = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
            op(1'($urandom), a, $urandom, b, NH'($urandom));
        end

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule